// File: doc/BRIEF.md
# Interrupt Priority Selector

This block picks which interrupt, if any, a hart takes in the current cycle. It has no state and no clock. It receives the vector of interrupts that are both pending and individually enabled, a per-bit delegation mask, the current privilege level, the machine and supervisor global enable bits, and a flag that is high while the hart sits in debug mode. It returns a take strobe and an XLEN-wide cause word whose top bit marks the word as an interrupt cause.

Qualification works in two tiers. Machine-level candidates are the pending bits that are not delegated, kept only when machine interrupts are enabled at the current privilege. Supervisor-level candidates are the delegated pending bits, kept only when supervisor interrupts are enabled. Any surviving machine-level candidate masks every supervisor-level one.

The surviving set then passes through a fixed group order. Nonstandard lines rank first, then external, then software, then timer. The lowest set index inside the winning group becomes the cause. The trap-entry logic that consumes the result sits outside this block.

Top module: `irq_prio_sel`

## Requirements
- R1: Privilege is encoded U=0, S=1, M=3. Machine-level interrupts are enabled when the privilege is below 3, or when it is 3 and `mie_i` is 1.
- R2: Machine-level candidates are the bits of `pend_i` whose `deleg_i` bit is 0, kept only while machine-level interrupts are enabled.
- R3: Supervisor-level candidates are used only when there is no machine-level candidate. They are the bits of `pend_i` whose `deleg_i` bit is 1.
- R4: Supervisor-level interrupts are enabled when the privilege is 0, or when it is 1 and `sie_i` is 1. At privilege 2 (reserved), machine-level interrupts are enabled and supervisor-level interrupts are not.
- R5: While `dbg_i` is 1, `take_o` is 0 whatever the other inputs are.
- R6: Candidates are ranked by group, with the first nonempty group winning:
  - nonstandard bits (index above 11);
  - external bits 9 and 11;
  - software bits 1 and 3;
  - timer bits 5 and 7.
- R7: Within the winning group, the lowest set bit index is chosen.
- R8: When `take_o` is 1, `cause_o` has bit XLEN-1 set, the chosen index in its low bits, and zeros elsewhere. When `take_o` is 0, `cause_o` is all zeros.
- R9: Bits 0, 2, 4, 6, 8 and 10 belong to no group. A candidate set made only of such bits yields no take.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pend_i | input | NUM_IRQ | Interrupts that are pending and individually enabled |
| deleg_i | input | NUM_IRQ | Delegation mask; 1 hands that bit to supervisor level |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| dbg_i | input | 1 | Hart is in debug mode |
| take_o | output | 1 | An interrupt is to be taken now |
| cause_o | output | XLEN | Interrupt cause: top bit set, index in low bits |

## Verification
Both results are purely combinational, so `take_o` and `cause_o` are due in the same cycle as the inputs that produce them, with zero register stages. The bench changes inputs on the falling clock edge and samples the outputs a quarter period later, well before the next rising edge, so every comparison sees settled values for exactly one input set. Each table row, and each directed case that follows it, is checked within that single window before the next stimulus is applied.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned SSIP_POS = 1;
  localparam int unsigned MSIP_POS = 3;
  localparam int unsigned STIP_POS = 5;
  localparam int unsigned MTIP_POS = 7;
  localparam int unsigned SEIP_POS = 9;
  localparam int unsigned MEIP_POS = 11;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } priv_e;
endpackage

// File: rtl/irq_cand_qual.sv
module irq_cand_qual
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  priv_e              priv_i,
  input  logic               mie_i,
  input  logic               sie_i,
  output logic [NUM_IRQ-1:0] cand_o
);
  logic               m_en, s_en;
  logic [NUM_IRQ-1:0] m_cand, s_cand;

  always_comb begin
    m_en   = (priv_i != PRIV_M) || mie_i;
    s_en   = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && sie_i);
    m_cand = pend_i & ~deleg_i & {NUM_IRQ{m_en}};
    s_cand = pend_i &  deleg_i & {NUM_IRQ{s_en}};
    // any machine-level candidate hides all supervisor-level ones
    cand_o = (|m_cand) ? m_cand : s_cand;
  end
endmodule

// File: rtl/irq_group_mask.sv
module irq_group_mask
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] cand_i,
  output logic [NUM_IRQ-1:0] win_o
);
  function automatic logic [NUM_IRQ-1:0] bit_at(int unsigned p);
    logic [NUM_IRQ-1:0] m;
    m = '0;
    if (p < NUM_IRQ) m[p] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_IRQ-1:0] EXT_M = bit_at(SEIP_POS) | bit_at(MEIP_POS);
  localparam logic [NUM_IRQ-1:0] SW_M  = bit_at(SSIP_POS) | bit_at(MSIP_POS);
  localparam logic [NUM_IRQ-1:0] TMR_M = bit_at(STIP_POS) | bit_at(MTIP_POS);

  logic [NUM_IRQ-1:0] nstd_m;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_nstd
    assign nstd_m[g] = (g > MEIP_POS);
  end

  logic [NUM_IRQ-1:0] c_nstd, c_ext, c_sw, c_tmr;

  always_comb begin
    c_nstd = cand_i & nstd_m;
    c_ext  = cand_i & EXT_M;
    c_sw   = cand_i & SW_M;
    c_tmr  = cand_i & TMR_M;
    if (|c_nstd)     win_o = c_nstd;
    else if (|c_ext) win_o = c_ext;
    else if (|c_sw)  win_o = c_sw;
    else             win_o = c_tmr;
  end
endmodule

// File: rtl/irq_lsb_index.sv
module irq_lsb_index #(
  parameter int unsigned NUM_IRQ = 16,
  localparam int unsigned IW = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] vec_i,
  output logic               valid_o,
  output logic [IW-1:0]      idx_o
);
  always_comb begin
    valid_o = |vec_i;
    idx_o   = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_prio_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NUM_IRQ = 16,
  localparam int unsigned IW     = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               mie_i,
  input  logic               sie_i,
  input  logic               dbg_i,
  output logic               take_o,
  output logic [XLEN-1:0]    cause_o
);
  logic [NUM_IRQ-1:0] cand, win;
  logic               win_valid;
  logic [IW-1:0]      win_idx;

  irq_cand_qual #(.NUM_IRQ(NUM_IRQ)) u_qual (
    .pend_i (pend_i),
    .deleg_i(deleg_i),
    .priv_i (priv_e'(priv_i)),
    .mie_i  (mie_i),
    .sie_i  (sie_i),
    .cand_o (cand)
  );

  irq_group_mask #(.NUM_IRQ(NUM_IRQ)) u_grp (
    .cand_i(cand),
    .win_o (win)
  );

  irq_lsb_index #(.NUM_IRQ(NUM_IRQ)) u_enc (
    .vec_i  (win),
    .valid_o(win_valid),
    .idx_o  (win_idx)
  );

  always_comb begin
    take_o  = win_valid && !dbg_i;
    cause_o = '0;
    if (take_o) begin
      cause_o[XLEN-1]  = 1'b1;
      cause_o[IW-1:0]  = win_idx;
    end
  end
endmodule

// File: rtl/irq_prio_sel_chk.sv
module irq_prio_sel_chk #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NUM_IRQ = 16,
  localparam int unsigned IW     = $clog2(NUM_IRQ)
) (
  input logic [NUM_IRQ-1:0] pend_i,
  input logic [NUM_IRQ-1:0] deleg_i,
  input logic [1:0]         priv_i,
  input logic               mie_i,
  input logic               sie_i,
  input logic               dbg_i,
  input logic               take_o,
  input logic [XLEN-1:0]    cause_o
);
  logic [IW-1:0] idx;
  logic          m_live;

  always_comb begin
    idx    = cause_o[IW-1:0];
    m_live = |(pend_i & ~deleg_i) && ((priv_i != 2'd3) || mie_i);

    a_r5_debug_blocks : assert (!(dbg_i && take_o))
      else $error("R5: take during debug");
    a_r8_cause_flag : assert (!take_o || cause_o[XLEN-1])
      else $error("R8: interrupt flag missing");
    a_r8_idle_zero : assert (take_o || (cause_o == '0))
      else $error("R8: cause not zero without take");
    a_r2_pending_pick : assert (!take_o || ((32'(idx) < NUM_IRQ) && pend_i[idx]))
      else $error("R2: chosen bit not pending");
    a_r3_m_masks_s : assert (!(take_o && m_live) || !deleg_i[idx])
      else $error("R3: delegated bit chosen over machine candidate");
    a_r8_mid_zero : assert (!take_o || (cause_o[XLEN-2:IW] == '0))
      else $error("R8: stray cause bits");
  end
endmodule

bind irq_prio_sel irq_prio_sel_chk #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) u_chk (
  .pend_i (pend_i),
  .deleg_i(deleg_i),
  .priv_i (priv_i),
  .mie_i  (mie_i),
  .sie_i  (sie_i),
  .dbg_i  (dbg_i),
  .take_o (take_o),
  .cause_o(cause_o)
);

// File: tb/irq_prio_sel_bench.sv
module irq_prio_sel_bench;
  localparam int unsigned XLEN    = 64;
  localparam int unsigned NUM_IRQ = 16;
  localparam int          NVEC    = 15;

  logic               clk = 1'b0;
  logic [NUM_IRQ-1:0] pend, deleg;
  logic [1:0]         priv;
  logic               mie, sie, dbg;
  logic               take;
  logic [XLEN-1:0]    cause;
  int                 n_chk = 0;
  int                 n_fail = 0;
  logic               done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_sel #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) u_irq_prio_sel (
    .pend_i (pend),
    .deleg_i(deleg),
    .priv_i (priv),
    .mie_i  (mie),
    .sie_i  (sie),
    .dbg_i  (dbg),
    .take_o (take),
    .cause_o(cause)
  );

  // {pend, deleg, priv, mie, sie, dbg, exp_take, exp_idx}
  localparam logic [41:0] VEC [NVEC] = '{
    {16'h0800, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd11}, // R1 M, mie=1
    {16'h0800, 16'h0000, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0 }, // R1 M, mie=0
    {16'h0080, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7 }, // R1 below M
    {16'h0088, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3 }, // R6 sw > timer
    {16'h0A00, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd9 }, // R7 ext lowest
    {16'h0202, 16'h0222, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd9 }, // R3 S-level
    {16'h0202, 16'h0222, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0 }, // R4 S, sie=0
    {16'h0202, 16'h0222, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9 }, // R4 U
    {16'h0082, 16'h0002, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7 }, // R3 M masks S
    {16'h2800, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd13}, // R6 nonstd first
    {16'h3000, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd12}, // R7 nonstd lowest
    {16'h0800, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0 }, // R5 debug
    {16'h00A0, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5 }, // R7 timer lowest
    {16'h0001, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0 }, // R9 reserved bit
    {16'h0002, 16'h0002, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0 }  // R4 priv 2
  };

  task automatic apply(input logic [15:0] p, input logic [15:0] d, input logic [1:0] pv,
                       input logic m, input logic s, input logic g);
    @(negedge clk);
    pend = p; deleg = d; priv = pv; mie = m; sie = s; dbg = g;
    #5;
  endtask

  task automatic check(input string req, input logic et, input logic [3:0] ei);
    logic [XLEN-1:0] ec;
    ec = '0;
    if (et) begin
      ec[XLEN-1] = 1'b1;
      ec[3:0]    = ei;
    end
    n_chk++;
    if (take !== et || cause !== ec) begin
      n_fail++;
      $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h", req, take, cause, et, ec);
    end
  endtask

  initial begin
    pend = '0; deleg = '0; priv = 2'd3; mie = 1'b0; sie = 1'b0; dbg = 1'b0;
    #5;
    check("R8 idle", 1'b0, 4'd0);

    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k][41:26], VEC[k][25:10], VEC[k][9:8], VEC[k][7], VEC[k][6], VEC[k][5]);
      check($sformatf("R1-table row %0d", k), VEC[k][4], VEC[k][3:0]);
    end

    // R9: every reserved standard bit together is still ignored
    apply(16'h0555, 16'h0000, 2'd3, 1'b1, 1'b1, 1'b0);
    check("R9 reserved set", 1'b0, 4'd0);
    // R6: software beats timer even at the higher index of the pair set
    apply(16'h00AA, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R6 sw group", 1'b1, 4'd1);
    // R2: delegated-only bits with S disabled at M: no take
    apply(16'h0AAA, 16'hFFFF, 2'd3, 1'b1, 1'b1, 1'b0);
    check("R2 all delegated at M", 1'b0, 4'd0);
    // R8: single nonstandard bits give their own index
    for (int b = 12; b < 16; b++) begin
      apply(16'(1 << b), 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0);
      check("R8 nonstd index", 1'b1, 4'(b));
    end
    // R5: debug cleared again restores take
    apply(16'h0008, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1);
    check("R5 debug on", 1'b0, 4'd0);
    apply(16'h0008, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b0);
    check("R5 debug off", 1'b1, 4'd3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule